// File: doc/BRIEF.md
# Bus Register Write Length Sniffer

This block listens to the write side of an AXI4-Lite link between a processor and a DMA engine and picks out the value written to the engine's transfer-length register. It has no outputs toward the bus. It only watches the AW and W handshakes, so the timing of the link does not change. When a write to the configured register address completes, the low bits of the written data become the new length.

The length is handed to a consumer in a second clock domain, such as a sample-clock data path that has to know how long the next DMA packet will be. The consumer sees a length bus and a strobe that is high for one cycle each time a new value lands. A build parameter selects a second variant that skips the crossing and presents the value and strobe in the bus clock domain. That variant suits a consumer that runs on the bus clock.

AXI4-Lite lets the address and data beats of one write complete in either order. The block therefore remembers whichever beat arrives first until its partner arrives. It assumes the master has at most one unpaired beat in flight.

Top module: `wlen_snoop`

## Requirements
- R1: When the AW and W handshakes complete in the same bus cycle and the AW address equals `LEN_ADDR`, the written value appears on `len_out` with `len_stb` high. In the bus-clock variant (`CROSS = 0`), `len_stb` and `len_out` update on the clock edge at which the handshakes complete.
- R2: When the matching AW handshake completes before its W handshake, the block remembers the match. The data of the next W handshake is then delivered.
- R3: When the W handshake completes before its AW handshake, the block holds the data. It delivers the data if the next AW handshake carries the matching address.
- R4: A write whose AW address differs from `LEN_ADDR` produces no strobe and leaves `len_out` unchanged, whichever order its beats take.
- R5: Each delivered value raises `len_stb` for exactly one destination cycle. `len_out` changes only in a cycle in which `len_stb` is high.
- R6: Only bits `[LEN_W-1:0]` of the write data are kept. The higher data bits are ignored.
- R7: If several length writes complete while a crossing is in progress, the most recently written value is the last one delivered. Every delivered value is one that was actually written, never a mix of two writes.
- R8: A beat whose valid is high while its ready is low is not a handshake and causes no capture.
- R9: After reset, `len_out` is 0 and `len_stb` is low.
- R10: In the bus-clock variant, every completed length write is delivered, including writes on back-to-back bus cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | AXI4-Lite bus clock |
| bus_rst_n | input | 1 | Asynchronous active-low reset, bus domain |
| mon_awaddr | input | ADDR_W | Observed write address |
| mon_awvalid | input | 1 | Observed write address valid |
| mon_awready | input | 1 | Observed write address ready |
| mon_wdata | input | DATA_W | Observed write data |
| mon_wvalid | input | 1 | Observed write data valid |
| mon_wready | input | 1 | Observed write data ready |
| dst_clk | input | 1 | Consumer clock (unused when CROSS = 0) |
| dst_rst_n | input | 1 | Asynchronous active-low reset, consumer domain (unused when CROSS = 0) |
| len_out | output | LEN_W | Last captured transfer length |
| len_stb | output | 1 | One-cycle pulse marking a new length |

## Verification
The bench completes length writes in three beat orders.
- A design that paired beats wrongly would drop writes that arrive address-first or data-first, or would deliver stale data.

Writes to a neighbouring address, partial handshakes with ready held low, and data with upper bits set probe for false captures.
- A design with a loose address match, a valid-only trigger or no truncation would give an extra strobe or a wrong value.

A burst of back-to-back length writes is issued while a crossing is still in progress.
- A design with an unguarded holding register would deliver a torn or stale value.
- A design with a lost-update bug would not finish on the last value written.

Strobe width and the stability of `len_out` between strobes are watched throughout. The bus-clock variant runs beside the crossing variant, so its timing on the handshake edge and its delivery of every write are checked as well.

// File: rtl/wlen_snoop.sv
module wlen_snoop #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 24,
  parameter logic [ADDR_W-1:0] LEN_ADDR = 'h10,
  parameter bit CROSS = 1'b1
) (
  input  logic              bus_clk,
  input  logic              bus_rst_n,
  input  logic [ADDR_W-1:0] mon_awaddr,
  input  logic              mon_awvalid,
  input  logic              mon_awready,
  input  logic [DATA_W-1:0] mon_wdata,
  input  logic              mon_wvalid,
  input  logic              mon_wready,
  input  logic              dst_clk,
  input  logic              dst_rst_n,
  output logic [LEN_W-1:0]  len_out,
  output logic              len_stb
);

  logic aw_hs, w_hs, aw_hit;
  logic [LEN_W-1:0] w_len;

  assign aw_hs  = mon_awvalid & mon_awready;
  assign w_hs   = mon_wvalid & mon_wready;
  assign aw_hit = (mon_awaddr == LEN_ADDR);
  assign w_len  = mon_wdata[LEN_W-1:0];

  generate
    if (LEN_W < DATA_W) begin : g_hi
      logic unused_hi;
      assign unused_hi = ^mon_wdata[DATA_W-1:LEN_W];
    end
  endgenerate

  // pairing of address and data beats
  logic             aw_pend, aw_pend_hit, w_pend;
  logic [LEN_W-1:0] w_pend_len;
  logic             aw_pend_n, aw_pend_hit_n, w_pend_n;
  logic [LEN_W-1:0] w_pend_len_n;
  logic             cap_fire;
  logic [LEN_W-1:0] cap_val;

  always_comb begin
    aw_pend_n     = aw_pend;
    aw_pend_hit_n = aw_pend_hit;
    w_pend_n      = w_pend;
    w_pend_len_n  = w_pend_len;
    cap_fire      = 1'b0;
    cap_val       = w_len;
    if (aw_pend) begin
      if (w_hs) begin
        cap_fire      = aw_pend_hit;
        cap_val       = w_len;
        aw_pend_n     = aw_hs;
        aw_pend_hit_n = aw_hit;
      end
    end else if (w_pend) begin
      if (aw_hs) begin
        cap_fire     = aw_hit;
        cap_val      = w_pend_len;
        w_pend_n     = w_hs;
        w_pend_len_n = w_len;
      end
    end else begin
      if (aw_hs && w_hs) begin
        cap_fire = aw_hit;
        cap_val  = w_len;
      end else if (aw_hs) begin
        aw_pend_n     = 1'b1;
        aw_pend_hit_n = aw_hit;
      end else if (w_hs) begin
        w_pend_n     = 1'b1;
        w_pend_len_n = w_len;
      end
    end
  end

  always_ff @(posedge bus_clk or negedge bus_rst_n) begin
    if (!bus_rst_n) begin
      aw_pend     <= 1'b0;
      aw_pend_hit <= 1'b0;
      w_pend      <= 1'b0;
      w_pend_len  <= '0;
    end else begin
      aw_pend     <= aw_pend_n;
      aw_pend_hit <= aw_pend_hit_n;
      w_pend      <= w_pend_n;
      w_pend_len  <= w_pend_len_n;
    end
  end

  p_pend_excl_r2: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    !(aw_pend && w_pend));

  p_wpend_kept_r3: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    (w_pend && !aw_hs) |=> (w_pend && $stable(w_pend_len)));

  generate
    if (CROSS) begin : g_cdc
      logic [LEN_W-1:0] hold, spare_val;
      logic             req_t, ack_s1, ack_s2, spare_v, busy;
      logic             d_s1, d_s2, d_s3;

      assign busy = req_t ^ ack_s2;

      always_ff @(posedge bus_clk or negedge bus_rst_n) begin
        if (!bus_rst_n) begin
          hold      <= '0;
          spare_val <= '0;
          spare_v   <= 1'b0;
          req_t     <= 1'b0;
          ack_s1    <= 1'b0;
          ack_s2    <= 1'b0;
        end else begin
          ack_s1 <= d_s3;
          ack_s2 <= ack_s1;
          if (cap_fire && !busy) begin
            hold    <= cap_val;
            req_t   <= ~req_t;
            spare_v <= 1'b0;
          end else if (cap_fire) begin
            spare_v   <= 1'b1;
            spare_val <= cap_val;
          end else if (spare_v && !busy) begin
            hold    <= spare_val;
            req_t   <= ~req_t;
            spare_v <= 1'b0;
          end
        end
      end

      always_ff @(posedge dst_clk or negedge dst_rst_n) begin
        if (!dst_rst_n) begin
          d_s1    <= 1'b0;
          d_s2    <= 1'b0;
          d_s3    <= 1'b0;
          len_out <= '0;
          len_stb <= 1'b0;
        end else begin
          d_s1 <= req_t;
          d_s2 <= d_s1;
          d_s3 <= d_s2;
          len_stb <= d_s2 ^ d_s3;
          if (d_s2 ^ d_s3) len_out <= hold;
        end
      end

      p_hold_stable_r7: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        busy |=> $stable(hold));

      p_toggle_cause_r1: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        !$stable(req_t) |-> ($past(cap_fire) || $past(spare_v)));

      p_stb_single_r5: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
        len_stb |=> !len_stb);

      p_len_quiet_r5: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
        !$stable(len_out) |-> len_stb);
    end else begin : g_byp
      logic unused_dst;
      assign unused_dst = dst_clk ^ dst_rst_n;

      always_ff @(posedge bus_clk or negedge bus_rst_n) begin
        if (!bus_rst_n) begin
          len_out <= '0;
          len_stb <= 1'b0;
        end else begin
          len_stb <= cap_fire;
          if (cap_fire) len_out <= cap_val;
        end
      end

      p_byp_follow_r10: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        len_stb |-> $past(cap_fire));

      p_byp_quiet_r5: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        !$stable(len_out) |-> len_stb);
    end
  endgenerate

endmodule

// File: tb/wlen_snoop_tb.sv
module wlen_snoop_tb_top;
  localparam logic [31:0] LADDR = 32'h10;

  logic        clk = 0, dclk = 0;
  logic        rst_n = 0, drst_n = 0;
  logic [31:0] awaddr = 0, wdata = 0;
  logic        awvalid = 0, awready = 0, wvalid = 0, wready = 0;
  logic [23:0] len_c, len_b;
  logic        stb_c, stb_b;

  always #4 clk = ~clk;
  always #6.5 dclk = ~dclk;

  wlen_snoop #(.LEN_ADDR(LADDR), .CROSS(1'b1)) dut_i (
    .bus_clk(clk), .bus_rst_n(rst_n),
    .mon_awaddr(awaddr), .mon_awvalid(awvalid), .mon_awready(awready),
    .mon_wdata(wdata), .mon_wvalid(wvalid), .mon_wready(wready),
    .dst_clk(dclk), .dst_rst_n(drst_n), .len_out(len_c), .len_stb(stb_c));

  wlen_snoop #(.LEN_ADDR(LADDR), .CROSS(1'b0)) dut_byp_i (
    .bus_clk(clk), .bus_rst_n(rst_n),
    .mon_awaddr(awaddr), .mon_awvalid(awvalid), .mon_awready(awready),
    .mon_wdata(wdata), .mon_wvalid(wvalid), .mon_wready(wready),
    .dst_clk(clk), .dst_rst_n(rst_n), .len_out(len_b), .len_stb(stb_b));

  int n_chk = 0, n_fail = 0;
  logic [23:0] log_c [64];
  int n_c = 0, n_b = 0;
  logic [23:0] last_b = 0;
  int stab_err = 0, dbl_err = 0;
  logic [23:0] prev_c = 0, prev_b = 0;
  logic prev_stb_c = 0;

  always @(negedge dclk) if (drst_n) begin
    if (stb_c) begin
      log_c[n_c % 64] = len_c;
      n_c++;
      if (prev_stb_c) dbl_err++;
    end else if (len_c !== prev_c) stab_err++;
    prev_c = len_c;
    prev_stb_c = stb_c;
  end

  always @(negedge clk) if (rst_n) begin
    if (stb_b) begin n_b++; last_b = len_b; end
    else if (len_b !== prev_b) stab_err++;
    prev_b = len_b;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_d(input int n);
    repeat (n) @(negedge dclk);
  endtask

  // mode 0: same cycle, 1: address first, 2: data first
  task automatic bus_wr(input logic [31:0] a, input logic [31:0] d, input int mode);
    @(negedge clk);
    if (mode == 0) begin
      awaddr = a; wdata = d; awvalid = 1; awready = 1; wvalid = 1; wready = 1;
      @(negedge clk);
      awvalid = 0; awready = 0; wvalid = 0; wready = 0;
    end else if (mode == 1) begin
      awaddr = a; awvalid = 1; awready = 1;
      @(negedge clk); awvalid = 0; awready = 0;
      repeat (3) @(negedge clk);
      wdata = d; wvalid = 1; wready = 1;
      @(negedge clk); wvalid = 0; wready = 0;
    end else begin
      wdata = d; wvalid = 1; wready = 1;
      @(negedge clk); wvalid = 0; wready = 0;
      repeat (3) @(negedge clk);
      awaddr = a; awvalid = 1; awready = 1;
      @(negedge clk); awvalid = 0; awready = 0;
    end
  endtask

  task automatic t_reset;
    chk(len_c == 0 && !stb_c, "R9 cross", {len_c, 7'b0, stb_c}, 0);
    chk(len_b == 0 && !stb_b, "R9 bypass", {len_b, 7'b0, stb_b}, 0);
  endtask

  task automatic t_same;
    int c0 = n_c;
    @(negedge clk);
    awaddr = LADDR; wdata = 32'h0000_1234; awvalid = 1; awready = 1; wvalid = 1; wready = 1;
    @(negedge clk);
    awvalid = 0; awready = 0; wvalid = 0; wready = 0;
    chk(stb_b && len_b == 24'h1234, "R1 bypass timing", {len_b, 7'b0, stb_b}, {24'h1234, 8'h1});
    @(negedge clk);
    chk(!stb_b, "R5 bypass single strobe", stb_b, 0);
    wait_d(12);
    chk(n_c == c0 + 1, "R1 cross count", n_c - c0, 1);
    chk(len_c == 24'h1234, "R1 cross value", len_c, 24'h1234);
  endtask

  task automatic t_aw_first;
    int c0 = n_c;
    bus_wr(LADDR, 32'h0000_0ABC, 1);
    wait_d(12);
    chk(n_c == c0 + 1 && len_c == 24'h0ABC, "R2 address first", len_c, 24'h0ABC);
    chk(len_b == 24'h0ABC, "R2 bypass", len_b, 24'h0ABC);
  endtask

  task automatic t_w_first;
    int c0 = n_c;
    bus_wr(LADDR, 32'h0000_7777, 2);
    wait_d(12);
    chk(n_c == c0 + 1 && len_c == 24'h7777, "R3 data first", len_c, 24'h7777);
    chk(len_b == 24'h7777, "R3 bypass", len_b, 24'h7777);
  endtask

  task automatic t_other_addr;
    int c0 = n_c;
    int b0 = n_b;
    for (int m = 0; m < 3; m++) bus_wr(32'h14, 32'h0000_5555, m);
    bus_wr(32'h0, 32'h0000_6666, 0);
    wait_d(12);
    chk(n_c == c0, "R4 no strobe cross", n_c - c0, 0);
    chk(len_c == 24'h7777, "R4 value kept", len_c, 24'h7777);
    chk(n_b == b0 && len_b == 24'h7777, "R4 bypass", len_b, 24'h7777);
  endtask

  task automatic t_no_ready;
    int c0 = n_c;
    int b0 = n_b;
    @(negedge clk);
    awaddr = LADDR; wdata = 32'h0000_0BAD; awvalid = 1; wvalid = 1;
    repeat (5) @(negedge clk);
    awvalid = 0; wvalid = 0;
    wait_d(12);
    chk(n_c == c0 && len_c == 24'h7777, "R8 no handshake cross", len_c, 24'h7777);
    chk(n_b == b0, "R8 no handshake bypass", n_b - b0, 0);
    bus_wr(LADDR, 32'h0000_2222, 0);
    wait_d(12);
    chk(len_c == 24'h2222, "R8 clean after partial", len_c, 24'h2222);
  endtask

  task automatic t_upper;
    bus_wr(LADDR, 32'hA512_3456, 0);
    wait_d(12);
    chk(len_c == 24'h123456, "R6 truncation cross", len_c, 24'h123456);
    chk(len_b == 24'h123456, "R6 truncation bypass", len_b, 24'h123456);
  endtask

  task automatic t_burst;
    int c0 = n_c;
    int b0 = n_b;
    bit ok = 1;
    @(negedge clk);
    awaddr = LADDR; awvalid = 1; awready = 1; wvalid = 1; wready = 1;
    wdata = 32'h111;
    @(negedge clk); wdata = 32'h222;
    @(negedge clk); wdata = 32'h333;
    @(negedge clk);
    awvalid = 0; awready = 0; wvalid = 0; wready = 0;
    wait_d(30);
    chk(n_c > c0 && n_c <= c0 + 3, "R7 delivery count", n_c - c0, 2);
    chk(len_c == 24'h333, "R7 last value wins", len_c, 24'h333);
    for (int i = c0; i < n_c; i++)
      if (!(log_c[i % 64] inside {24'h111, 24'h222, 24'h333})) ok = 0;
    chk(ok, "R7 no torn value", ok, 1);
    chk(n_b == b0 + 3 && last_b == 24'h333, "R10 bypass every write", n_b - b0, 3);
  endtask

  task automatic t_stable;
    chk(stab_err == 0, "R5 length changes only with strobe", stab_err, 0);
    chk(dbl_err == 0, "R5 strobe one cycle", dbl_err, 0);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1; drst_n = 1;
    repeat (3) @(negedge clk);
    t_same;
    t_aw_first;
    t_w_first;
    t_other_addr;
    t_no_ready;
    t_upper;
    t_burst;
    t_stable;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule